// File: doc/BRIEF.md
# Flow-Through Late-Write Burst SRAM

A small synchronous SRAM with a flow-through read path and a delayed write path. It takes one command on every clock edge. A read returns its word in the same cycle the command is captured, because no output register sits in the path. A write command is captured on one edge, and its data and lane enables are captured on the following edge. Because of this offset, reads and writes can follow one another in any order without an idle cycle.

A load command captures a new address and direction. A continue command steps a 2-bit beat counter. The counter selects the low two address bits either as an exclusive-or with the start address or as a modulo-4 sum, and the mode pin chooses which one. The bus is driven only for a selected read with the output enable low and the snooze input low. A word that has been written but not yet committed to the array is forwarded to reads lane by lane.

Top module: `flowlw_sram`

## Requirements
- R1: After reset the data bus is not driven (`dout_en`=0, `dout`=0).
- R2: A selected load with `wr_n`=1 drives the word at that address on `dout`, with `dout_en`=1, in the cycle right after the capturing edge.
- R3: A write's data and lane enables are sampled on the enabled edge after its command. Lane i covers bits [9i+8:9i] and is written when `bw_n[i]`=0, or for every i when `gw_n`=0.
- R4: A read of an address whose write has been sampled but not committed returns the pending lanes merged over the stored word.
- R5: With `ilv`=1, beat k of a burst accesses the start address with its low two bits XOR k. The beat counter wraps after four beats.
- R6: With `ilv`=0, beat k accesses the low two bits (start + k) mod 4, and the upper bits stay unchanged.
- R7: A load is a deselect unless `ce0`=1, `ce1_n`=0 and `ce2`=1. The bus is not driven after a deselect.
- R8: `oe_n`=1 turns off the bus at once, with no clock edge.
- R9: While `cke_n`=1, clock edges change no state: the burst position, the captured command and any pending write all hold.
- R10: A continue command that follows a deselect is itself a deselect.
- R11: `snooze`=1 turns off the bus at once. Edges during snooze, and the first enabled edge after it is released, are deselects.
- R12: A read may directly follow a write, and a write may directly follow a read, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high freezes all state |
| addr | input | ADDR_W | Word address for load commands |
| wr_n | input | 1 | Direction on load: 1 read, 0 write |
| ld_n | input | 1 | 0 loads a new command, 1 continues the burst |
| ce0 | input | 1 | Chip enable, active high |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| bw_n | input | 4 | Lane write enables, active low, sampled one edge after the command |
| gw_n | input | 1 | Write all lanes, active low, sampled with the data |
| ilv | input | 1 | Burst order: 1 XOR, 0 modulo-4 add |
| oe_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Low-power request: deselects and turns off the bus |
| wdata | input | DATA_W | Write data, sampled one edge after the command |
| dout | output | DATA_W | Read data, 0 when not driven |
| dout_en | output | 1 | High when the bus is driven |

## Verification
The hardest case to reach is a read that lands on an address whose write data was sampled on that same edge and has not yet reached the array. Only part of the lanes should be replaced in that case. The stimulus first fills a word with all ones. It then issues a write command to that word, and on the next edge a read of the same address while the late data arrives with only two lane enables low. The expected merged word follows directly from the lane layout. Burst ordering is checked by writing a full burst in XOR order and reading it back in both orders, including the wrap onto a fifth beat.

// File: rtl/flowlw_sram.sv
module flowlw_sram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              ce0,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic [3:0]        bw_n,
  input  logic              gw_n,
  input  logic              ilv,
  input  logic              oe_n,
  input  logic              snooze,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int LANES  = 4;
  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              act, rd_q, snz_q, pend_v;
  logic [1:0]        beat;
  logic [ADDR_W-1:0] base, pend_addr;
  logic [DATA_W-1:0] pend_data, rd_word;
  logic [LANES-1:0]  pend_be;

  wire              sel    = ce0 & ~ce1_n & ce2;
  wire              asleep = snooze | snz_q;
  wire [1:0]        low    = ilv ? (base[1:0] ^ beat) : (base[1:0] + beat);
  wire [ADDR_W-1:0] cur    = {base[ADDR_W-1:2], low};
  wire [LANES-1:0]  lane_we = gw_n ? ~bw_n : {LANES{1'b1}};
  wire              hit    = pend_v && (pend_addr == cur);
  wire [DATA_W-1:0] stored = mem[cur];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= 1'b0;
      rd_q      <= 1'b1;
      snz_q     <= 1'b0;
      pend_v    <= 1'b0;
      beat      <= 2'd0;
      base      <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_be   <= '0;
    end else if (!cke_n) begin
      snz_q  <= snooze;
      pend_v <= act & ~rd_q;
      if (act & ~rd_q) begin
        pend_addr <= cur;
        pend_data <= wdata;
        pend_be   <= lane_we;
      end
      if (asleep) begin
        act <= 1'b0;
      end else if (!ld_n) begin
        act  <= sel;
        rd_q <= wr_n;
        base <= addr;
        beat <= 2'd0;
      end else if (act) begin
        beat <= beat + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!cke_n && pend_v) begin
      for (int i = 0; i < LANES; i++)
        if (pend_be[i]) mem[pend_addr][i*LANE_W +: LANE_W] <= pend_data[i*LANE_W +: LANE_W];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LANE_W +: LANE_W] = (hit && pend_be[g]) ? pend_data[g*LANE_W +: LANE_W]
                                                             : stored[g*LANE_W +: LANE_W];
  end

  assign dout_en = act & rd_q & ~oe_n & ~snooze;
  assign dout    = dout_en ? rd_word : '0;

  AST_CKE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable({act, rd_q, beat, base, pend_v, pend_addr, pend_data, pend_be})); // R9
  AST_SNOOZE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && (snooze || snz_q)) |=> !act); // R11
  AST_ADV_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !act && ld_n) |=> !act); // R10
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && act && ld_n && !snooze && !snz_q) |=> (beat == $past(beat) + 2'd1)); // R5
  AST_LATE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && act && !rd_q) |=> pend_v); // R3
  AST_CE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && !(ce0 && !ce1_n && ce2)) |=> !act); // R7
endmodule

// File: tb/test_flowlw_sram.sv
`timescale 1ns/1ps
module test_flowlw_sram;
  typedef struct packed {
    logic        ld_n, wr_n, sel;
    logic [3:0]  bw_n;
    logic        gw_n;
    logic [7:0]  addr;
    logic [35:0] wd;
    logic        ilv, en;
    logic [35:0] exp;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t v(logic ld, logic wr, logic s, logic [3:0] bw, logic gw, logic [7:0] a,
                             logic [35:0] wd, logic m, logic en, logic [35:0] ex, logic [7:0] rq);
    v = '{ld, wr, s, bw, gw, a, wd, m, en, ex, rq};
  endfunction

  localparam logic [35:0] FF = 36'hF_FFFF_FFFF, D0 = 36'h1_2345_6789, D1 = 36'h9_8765_4321;
  localparam logic [35:0] D3 = 36'h5_A5A5_A5A5, MRG = 36'hF_F803_FE00;
  localparam logic [35:0] E0 = 36'h1_0000_0020, E1 = 36'h1_0000_0021;
  localparam logic [35:0] E2 = 36'h1_0000_0022, E3 = 36'h1_0000_0023;
  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    v(0,0,1,4'hF,1,8'h12,0 ,1,0,0 ,3),   // write cmd
    v(0,0,1,4'h0,1,8'h10,FF,1,0,0 ,3),   // data for 0x12
    v(0,0,1,4'h0,1,8'h11,D0,1,0,0 ,3),
    v(0,1,1,4'h0,1,8'h10,D1,1,1,D0,12),  // R12 read after write, R2
    v(0,0,1,4'hF,1,8'h12,0 ,1,0,0 ,12),  // R12 write after read
    v(0,1,1,4'hA,1,8'h12,0 ,1,1,MRG,4),  // R4 lanes 0,2 forwarded
    v(0,0,1,4'hF,1,8'h13,0 ,1,0,0 ,3),
    v(0,1,1,4'hF,0,8'h13,D3,1,1,D3,3),   // R3 global write
    v(0,0,1,4'hF,1,8'h21,0 ,1,0,0 ,5),
    v(1,1,1,4'h0,1,8'h00,E1,1,0,0 ,5),
    v(1,1,1,4'h0,1,8'h00,E0,1,0,0 ,5),
    v(1,1,1,4'h0,1,8'h00,E3,1,0,0 ,5),
    v(0,1,1,4'h0,1,8'h21,E2,1,1,E1,5),   // R5 beat0
    v(1,1,1,4'hF,1,8'h00,0 ,1,1,E0,5),
    v(1,1,1,4'hF,1,8'h00,0 ,1,1,E3,5),
    v(1,1,1,4'hF,1,8'h00,0 ,1,1,E2,5),
    v(1,1,1,4'hF,1,8'h00,0 ,1,1,E1,5),   // R5 wrap
    v(0,1,1,4'hF,1,8'h21,0 ,0,1,E1,6),   // R6 linear
    v(1,1,1,4'hF,1,8'h00,0 ,0,1,E2,6),
    v(1,1,1,4'hF,1,8'h00,0 ,0,1,E3,6),
    v(1,1,1,4'hF,1,8'h00,0 ,0,1,E0,6),
    v(0,1,0,4'hF,1,8'h20,0 ,1,0,0 ,7),   // R7 deselect
    v(1,1,1,4'hF,1,8'h00,0 ,1,0,0 ,10),  // R10 ignored continue
    v(0,1,1,4'hF,1,8'h23,0 ,1,1,E3,7)
  };

  logic clk = 0, rst_n = 0, cke_n = 0, wr_n = 1, ld_n = 1, ce0 = 0, ce1_n = 1, ce2 = 0;
  logic gw_n = 1, ilv = 1, oe_n = 0, snooze = 0, dout_en;
  logic [3:0] bw_n = 4'hF;
  logic [7:0] addr = 0;
  logic [35:0] wdata = 0, dout;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flowlw_sram #(.ADDR_W(8), .DATA_W(36)) i_flowlw_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .addr(addr), .wr_n(wr_n), .ld_n(ld_n),
    .ce0(ce0), .ce1_n(ce1_n), .ce2(ce2), .bw_n(bw_n), .gw_n(gw_n), .ilv(ilv),
    .oe_n(oe_n), .snooze(snooze), .wdata(wdata), .dout(dout), .dout_en(dout_en));

  task automatic check(int req, logic en, logic [35:0] ex);
    checks++;
    if (dout_en !== en || (en && dout !== ex) || (!en && dout !== '0)) begin
      fails++;
      $display("FAIL R%0d: actual en=%0b dout=%h expected en=%0b dout=%h", req, dout_en, dout, en, en ? ex : '0);
    end
  endtask

  task automatic drive(logic ld, logic wr, logic s, logic [7:0] a);
    ld_n = ld; wr_n = wr; ce0 = s; ce1_n = ~s; ce2 = s; addr = a;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1, 0, 0);                      // R1 during reset
    @(negedge clk) rst_n = 1;
    #1 check(1, 0, 0);                   // R1 after release

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i].ld_n, VT[i].wr_n, VT[i].sel, VT[i].addr);
      bw_n = VT[i].bw_n; gw_n = VT[i].gw_n; wdata = VT[i].wd; ilv = VT[i].ilv;
      step();
      check(int'(VT[i].req), VT[i].en, VT[i].exp);
    end
    bw_n = 4'hF; gw_n = 1; ilv = 1;

    // R8: asynchronous output enable
    @(negedge clk) drive(0, 1, 1, 8'h20);
    step(); check(8, 1, E0);
    oe_n = 1; #1 check(8, 0, 0);
    oe_n = 0; #1 check(8, 1, E0);

    // R9: clock enable freeze
    @(negedge clk) begin cke_n = 1; drive(1, 1, 1, 8'h23); end
    step(); step(); check(9, 1, E0);
    @(negedge clk) drive(0, 1, 1, 8'h22);
    step(); check(9, 1, E0);
    @(negedge clk) begin cke_n = 0; drive(1, 1, 1, 8'h00); end
    step(); check(9, 1, E1);

    // R11: snooze with one recovery edge
    @(negedge clk) snooze = 1;
    #1 check(11, 0, 0);
    @(negedge clk) drive(0, 1, 1, 8'h22);
    step(); check(11, 0, 0);
    @(negedge clk) snooze = 0;
    step(); check(11, 0, 0);
    step(); check(11, 1, E2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule